// File: doc/BRIEF.md
# Cycle-Stealing DMA Bus Arbiter

This block shares one memory bus between a CPU and a single DMA engine. The CPU reports, on a two-bit phase input, which part of its op-code cycle it is in. Three of those phases touch RAM: instruction fetch, operand access and result writeback. The fourth is the execute phase, which works only on CPU registers. The arbiter lends the bus to the DMA engine only during execute phases. In every other phase the CPU owns the bus outright and sees no extra wait.

Software loads a start address and a word count, then issues a start strobe. From then on, each execute-phase cycle in which the external I/O device has a word ready becomes one stolen slot. In that slot the DMA engine writes the device's word to memory at the current address. It then steps the address by one and lowers the remaining count by one. When the last word has moved, the engine returns to idle and raises an interrupt. The interrupt stays high until the CPU acknowledges it.

Top module: `cyc_steal_dma`

## Requirements
- R1: After reset the engine is idle: `dmaBusy`, `dmaIrq` and `ioAck` are 0, the bus carries the CPU's address, data and write enable, and the loaded address and count are both 0.
- R2: `cpuPhase` encodes 0 = fetch, 1 = operand access, 2 = writeback, 3 = execute. The DMA engine holds the bus only in a cycle whose phase is 3. In phases 0 to 2, `busAddr`, `busWrData` and `busWrEn` equal `cpuAddr`, `cpuWrData` and `cpuWrEn`.
- R3: The grant is combinational. In the same cycle that `cpuPhase` leaves 3, `ioAck` drops and the bus returns to the CPU.
- R4: A cycle with `dmaBusy`, phase 3 and `ioReq` all high moves one word. In that cycle `busAddr` is the current DMA address, `busWrData` equals `ioData`, and `busWrEn` and `ioAck` are 1. From the next cycle the address is one higher and the remaining count is one lower.
- R5: While busy, a cycle with `ioReq` low moves no word, even in phase 3. The address and count keep their values.
- R6: On the edge that ends the slot carrying the last word, `dmaBusy` falls and `dmaIrq` rises. Exactly as many words move as were loaded into the count.
- R7: `dmaIrq` stays at 1 until a cycle with `irqAck` high, and it is 0 from the following cycle. A completion in the same cycle as an acknowledge wins.
- R8: A `startReq` while idle with a remaining count of zero is ignored. The engine stays idle and never takes the bus.
- R9: While busy, address writes, count writes and further start strobes are ignored. The running transfer continues from its own address for its own count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuPhase | input | 2 | CPU op-code phase, 3 = execute |
| cpuAddr | input | ADDR_W | CPU bus address |
| cpuWrData | input | DATA_W | CPU write data |
| cpuWrEn | input | 1 | CPU write enable |
| setAddrEn | input | 1 | Load start address (idle only) |
| setAddrVal | input | ADDR_W | Start address value |
| setCountEn | input | 1 | Load word count (idle only) |
| setCountVal | input | COUNT_W | Word count value |
| startReq | input | 1 | Start strobe |
| irqAck | input | 1 | Interrupt acknowledge |
| ioReq | input | 1 | Device has a word ready |
| ioData | input | DATA_W | Device word |
| ioAck | output | 1 | Device word taken this cycle |
| busAddr | output | ADDR_W | Shared bus address |
| busWrData | output | DATA_W | Shared bus write data |
| busWrEn | output | 1 | Shared bus write enable |
| dmaBusy | output | 1 | Transfer in progress |
| dmaIrq | output | 1 | Completion interrupt |

## Verification
The main function is first driven with an unbroken run of execute phases, which shows the basic address stepping and the exact word count. A mixed sequence then interleaves all three memory phases with execute slots, including execute-to-memory changes. This separates a grant gated on the phase in the same cycle from one that lags by a cycle. It also proves the CPU sees its own signals in every memory phase. Execute phases with the device not ready show that slots are stolen only on request. The bench also covers a zero-count start, setup writes made during a transfer, and an interrupt held over several cycles before it is acknowledged.

// File: rtl/csd_pkg.sv
package csd_pkg;

  // CPU op-code phase as reported on cpuPhase
  typedef enum logic [1:0] {
    PH_FETCH  = 2'd0,
    PH_OPER   = 2'd1,
    PH_WRBACK = 2'd2,
    PH_EXEC   = 2'd3
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadAddr;
    logic loadCount;
    logic step;
  } dpStrobe_t;

endpackage

// File: rtl/csd_path.sv
module csd_path
  import csd_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int COUNT_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic [ADDR_W-1:0]  setAddrVal,
  input  logic [COUNT_W-1:0] setCountVal,
  output logic [ADDR_W-1:0]  curAddr,
  output logic               countZero,
  output logic               countLast
);

  localparam logic [ADDR_W-1:0]  AddrOne  = ADDR_W'(1);
  localparam logic [COUNT_W-1:0] CountOne = COUNT_W'(1);

  logic [COUNT_W-1:0] wordsLeft;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
    end else if (strobe.loadAddr) begin
      curAddr <= setAddrVal;
    end else if (strobe.step) begin
      curAddr <= curAddr + AddrOne;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordsLeft <= '0;
    end else if (strobe.loadCount) begin
      wordsLeft <= setCountVal;
    end else if (strobe.step) begin
      wordsLeft <= wordsLeft - CountOne;
    end
  end

  assign countZero = (wordsLeft == '0);
  assign countLast = (wordsLeft == CountOne);

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> curAddr == $past(curAddr) + AddrOne);

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> wordsLeft == $past(wordsLeft) - CountOne);

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |-> !countZero);

  // R9
  setup_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadAddr || strobe.loadCount) |-> !strobe.step);

endmodule

// File: rtl/csd_ctrl.sv
module csd_ctrl
  import csd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] cpuPhase,
  input  logic       ioReq,
  input  logic       setAddrEn,
  input  logic       setCountEn,
  input  logic       startReq,
  input  logic       irqAck,
  input  logic       countZero,
  input  logic       countLast,
  output dpStrobe_t  strobe,
  output logic       grant,
  output logic       busy,
  output logic       irq
);

  typedef enum logic {ST_IDLE, ST_RUN} state_e;

  state_e state, stateNext;
  logic   execPhase;
  logic   startOk;
  logic   lastSlot;

  assign execPhase = (phase_e'(cpuPhase) == PH_EXEC);
  assign busy      = (state == ST_RUN);
  assign grant     = busy && execPhase && ioReq;
  assign startOk   = !busy && startReq && !countZero;
  assign lastSlot  = grant && countLast;

  always_comb begin
    strobe.loadAddr  = setAddrEn  && !busy;
    strobe.loadCount = setCountEn && !busy;
    strobe.step      = grant;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (startOk)  stateNext = ST_RUN;
      ST_RUN:  if (lastSlot) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irq <= 1'b0;
    end else if (lastSlot) begin
      irq <= 1'b1;
    end else if (irqAck) begin
      irq <= 1'b0;
    end
  end

  // R2
  no_mem_phase_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    grant |-> cpuPhase == 2'd3);

  // R6
  done_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    lastSlot |=> (!busy && irq));

  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !irqAck) |=> irq);

  // R7
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irq && irqAck && !lastSlot) |=> !irq);

  // R8
  zero_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && countZero) |=> !busy);

endmodule

// File: rtl/cyc_steal_dma.sv
module cyc_steal_dma
  import csd_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int COUNT_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         cpuPhase,
  input  logic [ADDR_W-1:0]  cpuAddr,
  input  logic [DATA_W-1:0]  cpuWrData,
  input  logic               cpuWrEn,
  input  logic               setAddrEn,
  input  logic [ADDR_W-1:0]  setAddrVal,
  input  logic               setCountEn,
  input  logic [COUNT_W-1:0] setCountVal,
  input  logic               startReq,
  input  logic               irqAck,
  input  logic               ioReq,
  input  logic [DATA_W-1:0]  ioData,
  output logic               ioAck,
  output logic [ADDR_W-1:0]  busAddr,
  output logic [DATA_W-1:0]  busWrData,
  output logic               busWrEn,
  output logic               dmaBusy,
  output logic               dmaIrq
);

  dpStrobe_t         strobe;
  logic              grant;
  logic              countZero;
  logic              countLast;
  logic [ADDR_W-1:0] dmaAddr;

  csd_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cpuPhase   (cpuPhase),
    .ioReq      (ioReq),
    .setAddrEn  (setAddrEn),
    .setCountEn (setCountEn),
    .startReq   (startReq),
    .irqAck     (irqAck),
    .countZero  (countZero),
    .countLast  (countLast),
    .strobe     (strobe),
    .grant      (grant),
    .busy       (dmaBusy),
    .irq        (dmaIrq)
  );

  csd_path #(
    .ADDR_W  (ADDR_W),
    .COUNT_W (COUNT_W)
  ) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .setAddrVal  (setAddrVal),
    .setCountVal (setCountVal),
    .curAddr     (dmaAddr),
    .countZero   (countZero),
    .countLast   (countLast)
  );

  // single owner of the bus: DMA in a granted slot, CPU otherwise
  assign ioAck     = grant;
  assign busAddr   = grant ? dmaAddr : cpuAddr;
  assign busWrData = grant ? ioData  : cpuWrData;
  assign busWrEn   = grant ? 1'b1    : cpuWrEn;

  // R2
  cpu_owns_mem_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuPhase != 2'd3) |-> (busAddr == cpuAddr && busWrEn == cpuWrEn && !ioAck));

  // R5
  idle_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dmaBusy && !ioReq) |=> $stable(dmaAddr));

endmodule

// File: tb/test_cyc_steal_dma.sv
module test_cyc_steal_dma;

  localparam int ClkPeriod = 10;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int CW = 8;
  localparam logic [AW-1:0] CpuA = 16'hC0DE;
  localparam logic [DW-1:0] CpuD = 16'h1234;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [1:0]    cpuPhase = 2'd0;
  logic [AW-1:0] cpuAddr = CpuA;
  logic [DW-1:0] cpuWrData = CpuD;
  logic          cpuWrEn = 1'b0;
  logic          setAddrEn = 1'b0;
  logic [AW-1:0] setAddrVal = '0;
  logic          setCountEn = 1'b0;
  logic [CW-1:0] setCountVal = '0;
  logic          startReq = 1'b0;
  logic          irqAck = 1'b0;
  logic          ioReq = 1'b0;
  logic [DW-1:0] ioData = '0;
  logic          ioAck;
  logic [AW-1:0] busAddr;
  logic [DW-1:0] busWrData;
  logic          busWrEn;
  logic          dmaBusy;
  logic          dmaIrq;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(ClkPeriod/2) clk = ~clk;

  cyc_steal_dma #(.ADDR_W(AW), .DATA_W(DW), .COUNT_W(CW)) i_cyc_steal_dma (
    .clk(clk), .rstN(rstN), .cpuPhase(cpuPhase), .cpuAddr(cpuAddr),
    .cpuWrData(cpuWrData), .cpuWrEn(cpuWrEn), .setAddrEn(setAddrEn),
    .setAddrVal(setAddrVal), .setCountEn(setCountEn), .setCountVal(setCountVal),
    .startReq(startReq), .irqAck(irqAck), .ioReq(ioReq), .ioData(ioData),
    .ioAck(ioAck), .busAddr(busAddr), .busWrData(busWrData), .busWrEn(busWrEn),
    .dmaBusy(dmaBusy), .dmaIrq(dmaIrq)
  );

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // inputs change 1 time unit after a rising edge; checks 3 units later
  task automatic nextCycle();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    #3;
  endtask

  task automatic setupAndStart(logic [AW-1:0] a, logic [CW-1:0] n);
    cpuPhase = 2'd0;
    setAddrEn = 1'b1; setAddrVal = a;
    setCountEn = 1'b1; setCountVal = n;
    nextCycle();
    setAddrEn = 1'b0; setCountEn = 1'b0;
    startReq = 1'b1;
    nextCycle();
    startReq = 1'b0;
  endtask

  task automatic ackIrq();
    irqAck = 1'b1;
    nextCycle();
    irqAck = 1'b0;
  endtask

  task automatic testReset();
    cpuPhase = 2'd3; ioReq = 1'b1; cpuWrEn = 1'b1;
    settle();
    chk("R1", "busy", int'(dmaBusy), 0);
    chk("R1", "irq", int'(dmaIrq), 0);
    chk("R1", "ioAck", int'(ioAck), 0);
    chk("R1", "busAddr", int'(busAddr), int'(CpuA));
    chk("R1", "busWrData", int'(busWrData), int'(CpuD));
    chk("R1", "busWrEn", int'(busWrEn), 1);
    // zero count after reset: start is refused (R1 and R8)
    startReq = 1'b1;
    nextCycle();
    startReq = 1'b0;
    settle();
    chk("R1", "busy after start at zero count", int'(dmaBusy), 0);
    chk("R8", "ioAck after zero-count start", int'(ioAck), 0);
    ioReq = 1'b0; cpuWrEn = 1'b0;
    nextCycle();
  endtask

  task automatic testStraightRun();
    setupAndStart(16'h0040, 8'd3);
    cpuPhase = 2'd3; ioReq = 1'b1;
    for (int i = 0; i < 3; i++) begin
      ioData = DW'(16'hA100 + i);
      settle();
      chk("R4", "ioAck", int'(ioAck), 1);
      chk("R4", "busAddr", int'(busAddr), 16'h0040 + i);
      chk("R4", "busWrData", int'(busWrData), 16'hA100 + i);
      chk("R4", "busWrEn", int'(busWrEn), 1);
      nextCycle();
    end
    settle();
    chk("R6", "busy after last word", int'(dmaBusy), 0);
    chk("R6", "irq after last word", int'(dmaIrq), 1);
    chk("R6", "no extra word", int'(ioAck), 0);
    ioReq = 1'b0;
    ackIrq();
  endtask

  task automatic testInterleave();
    logic [1:0] pat [7] = '{2'd0, 2'd3, 2'd1, 2'd3, 2'd2, 2'd3, 2'd3};
    int expAddr = 16'h0100;
    int left = 4;
    setupAndStart(16'h0100, 8'd4);
    ioReq = 1'b1;
    for (int i = 0; i < 7; i++) begin
      cpuPhase = pat[i];
      ioData = DW'(16'hB000 + i);
      settle();
      if (pat[i] == 2'd3 && left > 0) begin
        chk("R4", "ioAck in execute", int'(ioAck), 1);
        chk("R4", "busAddr in execute", int'(busAddr), expAddr);
        chk("R4", "busWrData in execute", int'(busWrData), 16'hB000 + i);
        expAddr++;
        left--;
      end else begin
        chk("R3", "ioAck off execute", int'(ioAck), 0);
        chk("R2", "busAddr in memory phase", int'(busAddr), int'(CpuA));
        chk("R2", "busWrData in memory phase", int'(busWrData), int'(CpuD));
        chk("R2", "busWrEn in memory phase", int'(busWrEn), 0);
      end
      nextCycle();
    end
    cpuPhase = 2'd0; ioReq = 1'b0;
    settle();
    chk("R6", "all words moved", left, 0);
    chk("R6", "busy cleared", int'(dmaBusy), 0);
    chk("R6", "irq raised", int'(dmaIrq), 1);
    ackIrq();
  endtask

  task automatic testNoRequest();
    setupAndStart(16'h0200, 8'd2);
    cpuPhase = 2'd3; ioReq = 1'b0;
    for (int i = 0; i < 3; i++) begin
      settle();
      chk("R5", "ioAck without request", int'(ioAck), 0);
      chk("R5", "bus stays with CPU", int'(busAddr), int'(CpuA));
      chk("R5", "still busy", int'(dmaBusy), 1);
      nextCycle();
    end
    ioReq = 1'b1;
    for (int i = 0; i < 2; i++) begin
      settle();
      chk("R5", "address unchanged by idle slots", int'(busAddr), 16'h0200 + i);
      nextCycle();
    end
    ioReq = 1'b0;
    settle();
    chk("R5", "done after two words", int'(dmaBusy), 0);
  endtask

  task automatic testIrqHold();
    cpuPhase = 2'd0;
    for (int i = 0; i < 5; i++) begin
      settle();
      chk("R7", "irq held", int'(dmaIrq), 1);
      nextCycle();
    end
    ackIrq();
    settle();
    chk("R7", "irq cleared by ack", int'(dmaIrq), 0);
    nextCycle();
  endtask

  task automatic testZeroStart();
    startReq = 1'b1;
    nextCycle();
    startReq = 1'b0;
    cpuPhase = 2'd3; ioReq = 1'b1;
    for (int i = 0; i < 2; i++) begin
      settle();
      chk("R8", "busy after zero-count start", int'(dmaBusy), 0);
      chk("R8", "no grant", int'(ioAck), 0);
      nextCycle();
    end
    ioReq = 1'b0; cpuPhase = 2'd0;
  endtask

  task automatic testBusyWrites();
    setupAndStart(16'h0300, 8'd2);
    cpuPhase = 2'd0;
    setAddrEn = 1'b1; setAddrVal = 16'h0777;
    setCountEn = 1'b1; setCountVal = 8'd9;
    startReq = 1'b1;
    nextCycle();
    setAddrEn = 1'b0; setCountEn = 1'b0; startReq = 1'b0;
    cpuPhase = 2'd3; ioReq = 1'b1;
    for (int i = 0; i < 3; i++) begin
      settle();
      if (i < 2) begin
        chk("R9", "grant continues", int'(ioAck), 1);
        chk("R9", "original address kept", int'(busAddr), 16'h0300 + i);
      end else begin
        chk("R9", "original count kept", int'(ioAck), 0);
        chk("R9", "idle after original count", int'(dmaBusy), 0);
      end
      nextCycle();
    end
    ioReq = 1'b0; cpuPhase = 2'd0;
    ackIrq();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    testReset();
    rstN = 1'b1;
    nextCycle();
    testReset();
    testStraightRun();
    testInterleave();
    testNoRequest();
    testIrqHold();
    testZeroStart();
    testBusyWrites();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule